// File: doc/BRIEF.md
# Single-Lane Four-Register Structure Store

This block carries out one store of a four-element structure gathered from a single lane. A caller offers four 128-bit vector register values, an element size, a lane index, a base address and a writeback choice. The block picks the element at that lane from each of the four registers. It then writes the four elements to memory as one packed record, the first register's element at the lowest address. Each element goes out as a single write beat over a valid/ready port.

When the operation finishes, the block reports an updated base address. The base can stay as it was, move forward by four times the element size, or move forward by a general register value. The block checks the lane index against the element size, and it refuses a register writeback whose offset source is the zero register. A refused operation issues no write and no writeback. The block takes one operation at a time and captures all operands on acceptance, so the caller may change its inputs as soon as the operation is accepted.

Top module: `lane_struct_store`

## Requirements
- R1: `op_esize` encodes the element size as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Each beat's `mem_wdata` carries the chosen lane's element in its low bits, with the bits above it at zero. Lane L of size W bits occupies bits [L*W +: W] of its register.
- R2: An accepted legal operation issues exactly four beats in register order. Beat k carries the element of register k, taken from `op_vecs[k*128 +: 128]`, at address base + k × (element bytes).
- R3: `mem_wstrb` has its low (element bytes) bits set and the rest clear: 0x01, 0x03, 0x0F or 0xFF for sizes 0 to 3.
- R4: A beat advances only on a cycle where `mem_valid` and `mem_ready` are both high. While the beat is stalled, its address, data and strobe stay unchanged.
- R5: A lane index of at least 16, 8, 4 or 2 for sizes 0 to 3 raises `err` together with `done`. In that case no beat is issued and `wb_we` stays low.
- R6: `op_wb_mode` 0 or 3 leaves the base unchanged: `wb_we` is low and `wb_base` is the base. Mode 1 gives base + 4 × (element bytes) with `wb_we` high. Mode 2 gives base + `op_wb_offset` with `wb_we` high.
- R7: Mode 2 with `op_off_zero` high is refused. It gives `err`, no beats, `wb_we` low and `wb_base` equal to the base. The flag has no effect in the other modes.
- R8: `done` is a one-cycle pulse. It comes in the cycle after the last beat is accepted, or in the cycle after acceptance for a refused operation. `err`, `wb_we` and `wb_base` are meaningful while `done` is high.
- R9: `op_ready` is high only while idle. An operation is accepted when `op_valid` and `op_ready` are both high. Input changes after acceptance do not affect the operation in flight.
- R10: After reset, `op_ready` is high and `mem_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation will be taken |
| op_esize | input | 2 | Element size code |
| op_lane | input | 4 | Lane index |
| op_vecs | input | 512 | Four source registers, register k at bits [k*128 +: 128] |
| op_base | input | 64 | Base address |
| op_wb_mode | input | 2 | Writeback choice: none, immediate, register, none |
| op_wb_offset | input | 64 | General register offset for mode 2 |
| op_off_zero | input | 1 | Offset source is the zero register |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 64 | Beat address |
| mem_wdata | output | 64 | Beat data, element in low bits |
| mem_wstrb | output | 8 | Byte enables for the beat |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Operation refused, valid with done |
| wb_we | output | 1 | Base writeback requested, valid with done |
| wb_base | output | 64 | New base value, valid with done |

## Verification
Two things can meet in one cycle: acceptance of the fourth write beat, and a new operation already waiting at the input. The bench keeps `op_valid` high for the whole of each operation and scrambles the base, lane, size and register data right after acceptance. Memory readiness is random at several rates, so the final handshake lands on many different cycles. The run is judged on four points: `op_ready` stays low through the beats and the done cycle, every beat still matches the originally captured operands, `done` comes exactly one cycle after the fourth accepted beat, and no second operation starts before the block is idle again.

// File: rtl/sss_pkg.sv
`timescale 1ns/1ps
package sss_pkg;
  typedef enum logic [1:0] {ES_B = 2'd0, ES_H = 2'd1, ES_W = 2'd2, ES_D = 2'd3} esize_e;
  typedef enum logic [1:0] {WB_NONE = 2'd0, WB_IMM = 2'd1, WB_REG = 2'd2, WB_RSV = 2'd3} wbmode_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BEAT = 2'd1, ST_DONE = 2'd2} state_e;
endpackage

// File: rtl/sss_op_check.sv
`timescale 1ns/1ps
// Legality of an offered operation: lane range per size, zero-register offset.
module sss_op_check #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 4
) (
  input  logic [1:0]        esize,
  input  logic [LANE_W-1:0] lane,
  input  logic [1:0]        mode,
  input  logic              off_zero,
  output logic              bad
);
  import sss_pkg::*;
  localparam int LANES = VEC_W / 8;

  logic [LANE_W:0] lanes_n;
  logic            lane_bad;
  logic            zr_bad;

  always_comb begin
    lanes_n  = (LANE_W+1)'(LANES >> esize);
    lane_bad = ({1'b0, lane} >= lanes_n);
    zr_bad   = (wbmode_e'(mode) == WB_REG) && off_zero;
    bad      = lane_bad || zr_bad;
  end
endmodule

// File: rtl/sss_lane_extract.sv
`timescale 1ns/1ps
// Pulls the same lane out of every source register, zero-extended.
module sss_lane_extract #(
  parameter int VEC_W  = 128,
  parameter int ELEM_W = 64,
  parameter int NREG   = 4,
  parameter int LANE_W = 4
) (
  input  logic [NREG*VEC_W-1:0]          vecs,
  input  logic [1:0]                     esize,
  input  logic [LANE_W-1:0]              lane,
  output logic [NREG-1:0][ELEM_W-1:0]    elems
);
  localparam int SH_W   = LANE_W + 6;
  localparam int EBYTES = ELEM_W / 8;

  logic [SH_W-1:0]   shamt;
  logic [ELEM_W-1:0] emask;

  always_comb begin
    shamt = SH_W'({lane, 3'b000}) << esize;
    for (int b = 0; b < EBYTES; b++) begin
      emask[b*8 +: 8] = (b < (1 << esize)) ? 8'hFF : 8'h00;
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [VEC_W-1:0] shifted;
    always_comb begin
      shifted  = vecs[r*VEC_W +: VEC_W] >> shamt;
      elems[r] = shifted[ELEM_W-1:0] & emask;
    end
  end
endmodule

// File: rtl/sss_addr_gen.sv
`timescale 1ns/1ps
// Beat address, byte strobe and post-index base computation.
module sss_addr_gen #(
  parameter int ADDR_W = 64,
  parameter int NREG   = 4,
  parameter int STRB_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        esize,
  input  logic [BEAT_W-1:0] beat,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] offset,
  input  logic              bad,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [STRB_W-1:0] strb,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              wb_en
);
  import sss_pkg::*;

  logic [ADDR_W-1:0] rec_bytes;

  always_comb begin
    beat_addr = base + (ADDR_W'(beat) << esize);
    rec_bytes = ADDR_W'(NREG) << esize;
    for (int i = 0; i < STRB_W; i++) begin
      strb[i] = (i < (1 << esize));
    end
  end

  always_comb begin
    wb_en   = 1'b0;
    wb_addr = base;
    if (!bad) begin
      unique case (wbmode_e'(mode))
        WB_IMM: begin
          wb_en   = 1'b1;
          wb_addr = base + rec_bytes;
        end
        WB_REG: begin
          wb_en   = 1'b1;
          wb_addr = base + offset;
        end
        default: begin
          wb_en   = 1'b0;
          wb_addr = base;
        end
      endcase
    end
  end
endmodule

// File: rtl/sss_ctrl.sv
`timescale 1ns/1ps
// Operation sequencer: idle, write beats, finish.
module sss_ctrl #(
  parameter int NREG   = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              bad_in,
  input  logic              beat_fire,
  output logic              idle,
  output logic              beat_act,
  output logic              fin,
  output logic              err_q,
  output logic [BEAT_W-1:0] beat
);
  import sss_pkg::*;

  state_e            state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              err_d;
  logic              last_beat;

  always_comb begin
    last_beat = (beat_q == BEAT_W'(NREG - 1));
    state_d   = state_q;
    beat_d    = beat_q;
    err_d     = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          err_d   = bad_in;
          beat_d  = '0;
          state_d = bad_in ? ST_DONE : ST_BEAT;
        end
      end
      ST_BEAT: begin
        if (beat_fire) begin
          if (last_beat) begin
            state_d = ST_DONE;
          end else begin
            beat_d = beat_q + BEAT_W'(1);
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    idle     = (state_q == ST_IDLE);
    beat_act = (state_q == ST_BEAT);
    fin      = (state_q == ST_DONE);
    beat     = beat_q;
  end
endmodule

// File: rtl/lane_struct_store.sv
`timescale 1ns/1ps
// Single-lane, four-register structure store with optional base post-index.
module lane_struct_store #(
  parameter  int VEC_W  = 128,
  parameter  int ADDR_W = 64,
  parameter  int ELEM_W = 64,
  parameter  int NREG   = 4,
  localparam int LANE_W = $clog2(VEC_W / 8),
  localparam int STRB_W = ELEM_W / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  output logic                    op_ready,
  input  logic [1:0]              op_esize,
  input  logic [LANE_W-1:0]       op_lane,
  input  logic [NREG*VEC_W-1:0]   op_vecs,
  input  logic [ADDR_W-1:0]       op_base,
  input  logic [1:0]              op_wb_mode,
  input  logic [ADDR_W-1:0]       op_wb_offset,
  input  logic                    op_off_zero,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ELEM_W-1:0]       mem_wdata,
  output logic [STRB_W-1:0]       mem_wstrb,
  output logic                    done,
  output logic                    err,
  output logic                    wb_we,
  output logic [ADDR_W-1:0]       wb_base
);
  localparam int BEAT_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic                  accept;
  logic                  bad_in;
  logic                  idle, beat_act, fin, err_q;
  logic [BEAT_W-1:0]     beat;
  logic                  beat_fire;

  logic [NREG*VEC_W-1:0] cap_vecs;
  logic [1:0]            cap_esize;
  logic [LANE_W-1:0]     cap_lane;
  logic [ADDR_W-1:0]     cap_base;
  logic [1:0]            cap_mode;
  logic [ADDR_W-1:0]     cap_off;

  logic [NREG-1:0][ELEM_W-1:0] elems;
  logic [ADDR_W-1:0]     beat_addr;
  logic [STRB_W-1:0]     strb;
  logic [ADDR_W-1:0]     wb_addr;
  logic                  wb_en;

  always_comb begin
    accept    = op_valid && idle;
    beat_fire = beat_act && mem_ready;
  end

  sss_op_check #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_check (
    .esize    (op_esize),
    .lane     (op_lane),
    .mode     (op_wb_mode),
    .off_zero (op_off_zero),
    .bad      (bad_in)
  );

  // Operand capture, clock-enabled by acceptance; data path needs no reset.
  always_ff @(posedge clk) begin
    if (accept) begin
      cap_vecs  <= op_vecs;
      cap_esize <= op_esize;
      cap_lane  <= op_lane;
      cap_base  <= op_base;
      cap_mode  <= op_wb_mode;
      cap_off   <= op_wb_offset;
    end
  end

  sss_ctrl #(.NREG(NREG), .BEAT_W(BEAT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .bad_in    (bad_in),
    .beat_fire (beat_fire),
    .idle      (idle),
    .beat_act  (beat_act),
    .fin       (fin),
    .err_q     (err_q),
    .beat      (beat)
  );

  sss_lane_extract #(
    .VEC_W(VEC_W), .ELEM_W(ELEM_W), .NREG(NREG), .LANE_W(LANE_W)
  ) u_extract (
    .vecs  (cap_vecs),
    .esize (cap_esize),
    .lane  (cap_lane),
    .elems (elems)
  );

  sss_addr_gen #(
    .ADDR_W(ADDR_W), .NREG(NREG), .STRB_W(STRB_W), .BEAT_W(BEAT_W)
  ) u_addr (
    .base      (cap_base),
    .esize     (cap_esize),
    .beat      (beat),
    .mode      (cap_mode),
    .offset    (cap_off),
    .bad       (err_q),
    .beat_addr (beat_addr),
    .strb      (strb),
    .wb_addr   (wb_addr),
    .wb_en     (wb_en)
  );

  always_comb begin
    op_ready  = idle;
    mem_valid = beat_act;
    mem_addr  = beat_addr;
    mem_wdata = elems[beat];
    mem_wstrb = strb;
    done      = fin;
    err       = fin && err_q;
    wb_we     = fin && wb_en;
    wb_base   = wb_addr;
  end
endmodule

// File: rtl/sss_checker.sv
`timescale 1ns/1ps
module sss_checker #(
  parameter int ADDR_W = 64,
  parameter int ELEM_W = 64,
  parameter int NREG   = 4,
  parameter int STRB_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ELEM_W-1:0] mem_wdata,
  input logic [STRB_W-1:0] mem_wstrb,
  input logic              done,
  input logic              err,
  input logic              wb_we
);
  localparam int CNT_W = $clog2(NREG + 1) + 1;
  logic [CNT_W-1:0] nbeats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbeats <= '0;
    end else if (op_valid && op_ready) begin
      nbeats <= '0;
    end else if (mem_valid && mem_ready) begin
      nbeats <= nbeats + CNT_W'(1);
    end
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wstrb));

  assert_strb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_wstrb[0] && ((mem_wstrb & (mem_wstrb + STRB_W'(1))) == '0));

  assert_four_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> nbeats == CNT_W'(NREG));

  assert_err_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !wb_we && nbeats == '0);

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || done) |-> !op_ready);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && nbeats == CNT_W'(NREG - 1) |=> done && !mem_valid);
endmodule

bind lane_struct_store sss_checker #(
  .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .NREG(NREG), .STRB_W(STRB_W)
) u_sss_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_wstrb (mem_wstrb),
  .done      (done),
  .err       (err),
  .wb_we     (wb_we)
);

// File: tb/lane_struct_store_tb.sv
`timescale 1ns/1ps
module lane_struct_store_tb;
  logic         clk;
  logic         rst_n;
  logic         op_valid;
  logic         op_ready;
  logic [1:0]   op_esize;
  logic [3:0]   op_lane;
  logic [511:0] op_vecs;
  logic [63:0]  op_base;
  logic [1:0]   op_wb_mode;
  logic [63:0]  op_wb_offset;
  logic         op_off_zero;
  logic         mem_valid;
  logic         mem_ready;
  logic [63:0]  mem_addr;
  logic [63:0]  mem_wdata;
  logic [7:0]   mem_wstrb;
  logic         done;
  logic         err;
  logic         wb_we;
  logic [63:0]  wb_base;

  int nchecks = 0;
  int nfail   = 0;

  lane_struct_store u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_esize(op_esize), .op_lane(op_lane), .op_vecs(op_vecs), .op_base(op_base),
    .op_wb_mode(op_wb_mode), .op_wb_offset(op_wb_offset), .op_off_zero(op_off_zero),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .done(done), .err(err),
    .wb_we(wb_we), .wb_base(wb_base)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] f_elem(logic [511:0] v, int r, int lane, int es);
    logic [127:0] rv;
    logic [127:0] sh;
    logic [63:0]  m;
    int w;
    w  = 8 << es;
    rv = v[r*128 +: 128];
    sh = rv >> (lane * w);
    m  = (es == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    return sh[63:0] & m;
  endfunction

  function automatic logic [7:0] f_strb(int es);
    logic [15:0] t;
    t = (16'd1 << (1 << es)) - 16'd1;
    return t[7:0];
  endfunction

  function automatic bit f_bad(int es, int lane, int mode, bit zr);
    return (lane >= (16 >> es)) || (mode == 2 && zr);
  endfunction

  function automatic logic [63:0] f_wb(logic [63:0] b, int mode, logic [63:0] off, int es, bit bad);
    if (bad) return b;
    if (mode == 1) return b + (64'd4 << es);
    if (mode == 2) return b + off;
    return b;
  endfunction

  function automatic logic [511:0] rnd_vecs();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic run_op(input int es, input int lane, input logic [63:0] base,
                        input int mode, input logic [63:0] off, input bit zr,
                        input int rdy_pct);
    logic [511:0] vecs;
    bit           bad;
    int           nb;
    int           last_fire;
    bit           got_done;
    vecs = rnd_vecs();
    bad  = f_bad(es, lane, mode, zr);
    @(negedge clk);
    op_esize     = 2'(es);
    op_lane      = 4'(lane);
    op_vecs      = vecs;
    op_base      = base;
    op_wb_mode   = 2'(mode);
    op_wb_offset = off;
    op_off_zero  = zr;
    op_valid     = 1'b1;
    #1;
    chk(op_ready == 1'b1, "R9", "op_ready while idle", 64'(op_ready), 64'd1);
    nb = 0; last_fire = -10; got_done = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      // keep a new operation pending with unrelated operands (R9)
      op_vecs      = rnd_vecs();
      op_base      = rnd64();
      op_lane      = 4'($urandom);
      op_esize     = 2'($urandom);
      op_wb_mode   = 2'($urandom);
      op_wb_offset = rnd64();
      mem_ready    = (($urandom % 100) < rdy_pct);
      #1;
      chk(op_ready == 1'b0, "R9", "op_ready while busy", 64'(op_ready), 64'd0);
      if (done) begin
        got_done = 1;
        if (bad) chk(cyc == 0, "R8", "refused done cycle", 64'(cyc), 64'd0);
        else     chk(last_fire == cyc - 1, "R8", "done after last beat", 64'(cyc), 64'(last_fire + 1));
        chk(mem_valid == 1'b0, "R8", "no beat with done", 64'(mem_valid), 64'd0);
        chk(err == bad, zr && mode == 2 ? "R7" : "R5", "err flag", 64'(err), 64'(bad));
        chk(nb == (bad ? 0 : 4), bad ? "R5" : "R2", "beat count", 64'(nb), bad ? 64'd0 : 64'd4);
        chk(wb_we == (!bad && (mode == 1 || mode == 2)), "R6", "wb_we", 64'(wb_we),
            64'(!bad && (mode == 1 || mode == 2)));
        chk(wb_base == f_wb(base, mode, off, es, bad), "R6", "wb_base", wb_base,
            f_wb(base, mode, off, es, bad));
        op_valid = 1'b0;
        break;
      end
      if (mem_valid) begin
        chk(nb < 4, "R2", "extra beat", 64'(nb), 64'd3);
        chk(mem_addr == base + (64'(nb) << es), "R2", "beat address", mem_addr, base + (64'(nb) << es));
        chk(mem_wdata == f_elem(vecs, nb, lane, es), "R1", "beat data", mem_wdata, f_elem(vecs, nb, lane, es));
        chk(mem_wstrb == f_strb(es), "R3", "strobe", 64'(mem_wstrb), 64'(f_strb(es)));
        if (mem_ready) begin
          nb++;
          last_fire = cyc;
        end else begin
          chk(1'b1, "R4", "stalled beat held", 64'(nb), 64'(nb));
        end
      end
    end
    chk(got_done, "R8", "operation finished", 64'(got_done), 64'd1);
    op_valid  = 1'b0;
    mem_ready = 1'b0;
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
    chk(op_ready == 1'b1, "R9", "idle after done", 64'(op_ready), 64'd1);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd5813);
    rst_n = 1'b0; op_valid = 1'b0; op_esize = '0; op_lane = '0; op_vecs = '0;
    op_base = '0; op_wb_mode = '0; op_wb_offset = '0; op_off_zero = 1'b0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(op_ready == 1'b1, "R10", "reset op_ready", 64'(op_ready), 64'd1);
    chk(mem_valid == 1'b0, "R10", "reset mem_valid", 64'(mem_valid), 64'd0);
    chk(done == 1'b0, "R10", "reset done", 64'(done), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed: every size, boundary lanes, all writeback modes
    for (int es = 0; es < 4; es++) begin
      run_op(es, 0, 64'h1000, 0, 64'h0, 1'b0, 100);
      run_op(es, (16 >> es) - 1, 64'h2000_0000_0000_0ff0, 1, 64'h0, 1'b0, 100);
      run_op(es, (16 >> es) - 1, 64'h3000, 2, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 40);
      if (es > 0) run_op(es, 16 >> es, 64'h4000, 1, 64'h0, 1'b0, 100);
      run_op(es, 15, 64'h5000, 3, 64'h0, 1'b0, 100);
      run_op(es, 0, 64'h6000, 2, 64'h40, 1'b1, 100);
      run_op(es, 0, 64'h7000, 1, 64'h40, 1'b1, 15);
    end
    // Random mix with varying memory readiness
    for (int n = 0; n < 150; n++) begin
      run_op($urandom % 4, $urandom % 16, rnd64(), $urandom % 4, rnd64(),
             ($urandom % 4) == 0, 10 + ($urandom % 91));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule